// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block moves a processor core from ordinary execution into an exception handler once the core has decided to take an event. On a start pulse it captures the event class, the three candidate vectors, the program counter, the pending delay-slot count, the status word, both stack pointers, the exception base and the core revision. In the following cycle it presents every architectural write the entry needs: the return address, with its target register chosen by class; the exception-status index word; the transformed status word; and the user/kernel stack swap. These appear as value buses with one-cycle write enables that the register file applies.

After the save cycle the sequencer requests a single 32-bit read of the handler address from the vector table at the exception base plus four times the vector number. It holds the request until it is granted and waits for the returned data. It then presents that data as the new program counter for one cycle, together with a done pulse.

A core revision below 32 selects a legacy entry flavour. In that flavour the status word is not stacked, the delay slot is not rewound and no exception-status word is written. An interrupt-lock pulse is issued, and a bus-fault event is refused with an error pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector number follows the event class encoding on `evt_i`: 2'b00 break takes `trap_vec_i`, 2'b01 NMI takes 0, 2'b10 bus fault takes `fault_vec_i`, and 2'b11 external interrupt takes `irq_vec_i`. It is observed through the read address `ebp_i + 4*vector`, computed modulo 2^32.
- R2: In the save cycle, which is the cycle after the start edge, exactly one of `erp_we_o` (break, bus fault, interrupt) or `nrp_we_o` (NMI) is high for one cycle, with the saved return address on `ret_addr_o`.
- R3: For an NMI the written status word has bit 30 (mode flag) cleared before any further transform.
- R4: In the newer flavour (`core_ver_i` >= 32), `exs_we_o` pulses in the save cycle and `exs_o` equals the vector number shifted left by 8 with all other bits zero. In the legacy flavour `exs_we_o` stays low.
- R5: In the newer flavour the return address is the PC minus `dslot_i`, and `dslot_clr_o` pulses when `dslot_i` is nonzero. In the legacy flavour the return address is the PC unchanged and `dslot_clr_o` stays low.
- R6: When status bit 6 (user flag) is set at start, `usp_we_o` and `sp_we_o` pulse in the save cycle with `usp_o` = `sp_i` and `sp_o` = `ksp_i`. Otherwise neither pulses.
- R7: `ccs_we_o` pulses in the save cycle. In the newer flavour `ccs_o` = ((c & 0xC0000000) | ((c << 12) >> 2)) & ~0x3FF, where c is the status after R3, so the user flag is cleared. In the legacy flavour `ccs_o` = c.
- R8: In the cycle after the save cycle `rd_req_o` rises with `rd_addr_o` and holds both steady until a cycle with `rd_gnt_i` high. The block then waits for `rd_valid_i`. In the cycle after valid, `pc_we_o` and `done_o` pulse for one cycle with `pc_o` equal to the returned `rd_data_i`.
- R9: In the legacy flavour `irq_lock_o` pulses in the save cycle. In the newer flavour it stays low.
- R10: A bus fault in the legacy flavour pulses `err_o` in the save cycle with no write enable, no read request and no done. The sequencer is idle again in the next cycle and accepts a new start there.
- R11: A start pulse while the sequencer is busy is ignored. Every saved value and the read address come from the inputs sampled at the accepted start edge.
- R12: After reset every write enable, `rd_req_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin entry (honoured only when idle) |
| evt_i | input | 2 | Event class |
| core_ver_i | input | 8 | Core revision; below 32 selects legacy flavour |
| trap_vec_i | input | 8 | Break vector |
| fault_vec_i | input | 8 | Bus-fault vector latched at fault time |
| irq_vec_i | input | 8 | Vector from the interrupt controller |
| pc_i | input | 32 | Current program counter |
| dslot_i | input | 2 | Pending delay-slot count |
| ccs_i | input | 32 | Condition/status word |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| ebp_i | input | 32 | Exception vector table base |
| erp_we_o | output | 1 | Write return address to the exception return register |
| nrp_we_o | output | 1 | Write return address to the NMI return register |
| ret_addr_o | output | 32 | Return address value |
| exs_we_o | output | 1 | Write exception-status word |
| exs_o | output | 32 | Exception-status word |
| ccs_we_o | output | 1 | Write status word |
| ccs_o | output | 32 | New status word |
| usp_we_o | output | 1 | Write user stack pointer |
| usp_o | output | 32 | User stack pointer value |
| sp_we_o | output | 1 | Write stack pointer |
| sp_o | output | 32 | Stack pointer value |
| dslot_clr_o | output | 1 | Clear delay-slot state |
| irq_lock_o | output | 1 | Set interrupt lock (legacy flavour) |
| err_o | output | 1 | Illegal legacy bus-fault entry |
| rd_req_o | output | 1 | Vector table read request |
| rd_addr_o | output | 32 | Vector table read address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data (handler address) |
| pc_we_o | output | 1 | Load new program counter |
| pc_o | output | 32 | New program counter |
| done_o | output | 1 | Entry complete |

## Verification
The save cycle is where most writes meet. An NMI taken from user mode with a pending delay slot in the newer flavour needs a mode-flag clear, a stack swap, a status shift, a delay-slot rewind and a return-register choice, all in one cycle. The bench provokes this both in directed cases and by drawing class, status bits, slot count and revision at random. It compares every enable and value in that one cycle against bench functions. The other collision is a new start that arrives during the save, fetch or error cycle while the input buses are being rescrambled. This is judged by checking that the read address, the returned PC and the next entry all follow only the start that was accepted.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        EV_BREAK = 2'd0,
        EV_NMI   = 2'd1,
        EV_BUSF  = 2'd2,
        EV_IRQ   = 2'd3
    } evt_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SAVE  = 3'd1,
        ST_FREQ  = 3'd2,
        ST_FWAIT = 3'd3,
        ST_DONE  = 3'd4
    } st_e;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter int VW = 8
) (
    input  evt_e          evt_i,
    input  logic [VW-1:0] trap_vec_i,
    input  logic [VW-1:0] fault_vec_i,
    input  logic [VW-1:0] irq_vec_i,
    output logic [VW-1:0] vec_o,
    output logic          to_nrp_o
);
    localparam logic [VW-1:0] NMI_VEC = '0;

    always_comb begin
        vec_o    = irq_vec_i;
        to_nrp_o = 1'b0;
        unique case (evt_i)
            EV_BREAK: vec_o = trap_vec_i;
            EV_NMI: begin
                vec_o    = NMI_VEC;
                to_nrp_o = 1'b1;
            end
            EV_BUSF:  vec_o = fault_vec_i;
            default:  vec_o = irq_vec_i;
        endcase
    end
endmodule

// File: rtl/exc_ccs_xform.sv
module exc_ccs_xform #(
    parameter int XLEN       = 32,
    parameter int M_BIT      = 30,
    parameter int KEEP_TOP   = 2,
    parameter int MODE_SHIFT = 10
) (
    input  logic [XLEN-1:0] ccs_i,
    input  logic            clr_m_i,
    input  logic            legacy_i,
    output logic [XLEN-1:0] ccs_o
);
    localparam logic [XLEN-1:0] ONES     = {XLEN{1'b1}};
    localparam logic [XLEN-1:0] TOP_MASK = ~(ONES >> KEEP_TOP);
    localparam logic [XLEN-1:0] LOW_MASK = ~(ONES << MODE_SHIFT);
    localparam int              LSHIFT   = MODE_SHIFT + KEEP_TOP;

    logic [XLEN-1:0] cleared;
    logic [XLEN-1:0] moved;
    logic [XLEN-1:0] stacked;

    always_comb begin
        cleared = ccs_i;
        if (clr_m_i) begin
            cleared[M_BIT] = 1'b0;
        end
        moved   = (cleared << LSHIFT) >> KEEP_TOP;
        stacked = ((cleared & TOP_MASK) | moved) & ~LOW_MASK;
        ccs_o   = legacy_i ? cleared : stacked;
    end
endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc #(
    parameter int XLEN    = 32,
    parameter int DSW     = 2,
    parameter int VW      = 8,
    parameter int EXS_LSB = 8
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [DSW-1:0]  dslot_i,
    input  logic            legacy_i,
    input  logic [VW-1:0]   vec_i,
    input  logic [XLEN-1:0] ebp_i,
    output logic [XLEN-1:0] ret_o,
    output logic [XLEN-1:0] exs_o,
    output logic [XLEN-1:0] tbl_addr_o
);
    localparam int PAD_D = XLEN - DSW;
    localparam int PAD_V = XLEN - VW;

    logic [XLEN-1:0] ds_ext;
    logic [XLEN-1:0] vec_ext;

    always_comb begin
        ds_ext     = {{PAD_D{1'b0}}, dslot_i};
        vec_ext    = {{PAD_V{1'b0}}, vec_i};
        ret_o      = legacy_i ? pc_i : (pc_i - ds_ext);
        exs_o      = vec_ext << EXS_LSB;
        tbl_addr_o = ebp_i + (vec_ext << 2);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int VW         = 8,
    parameter int DSW        = 2,
    parameter int CVW        = 8,
    parameter int LEGACY_LIM = 32,
    parameter int U_BIT      = 6,
    parameter int M_BIT      = 30,
    parameter int KEEP_TOP   = 2,
    parameter int MODE_SHIFT = 10,
    parameter int EXS_LSB    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      evt_i,
    input  logic [CVW-1:0]  core_ver_i,
    input  logic [VW-1:0]   trap_vec_i,
    input  logic [VW-1:0]   fault_vec_i,
    input  logic [VW-1:0]   irq_vec_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [DSW-1:0]  dslot_i,
    input  logic [XLEN-1:0] ccs_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] ksp_i,
    input  logic [XLEN-1:0] ebp_i,
    output logic            erp_we_o,
    output logic            nrp_we_o,
    output logic [XLEN-1:0] ret_addr_o,
    output logic            exs_we_o,
    output logic [XLEN-1:0] exs_o,
    output logic            ccs_we_o,
    output logic [XLEN-1:0] ccs_o,
    output logic            usp_we_o,
    output logic [XLEN-1:0] usp_o,
    output logic            sp_we_o,
    output logic [XLEN-1:0] sp_o,
    output logic            dslot_clr_o,
    output logic            irq_lock_o,
    output logic            err_o,
    output logic            rd_req_o,
    output logic [XLEN-1:0] rd_addr_o,
    input  logic            rd_gnt_i,
    input  logic            rd_valid_i,
    input  logic [XLEN-1:0] rd_data_i,
    output logic            pc_we_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o
);
    localparam logic [CVW-1:0] LEG_LIM = CVW'(LEGACY_LIM);

    typedef struct packed {
        evt_e            evt;
        logic            legacy;
        logic [VW-1:0]   trap_vec;
        logic [VW-1:0]   fault_vec;
        logic [VW-1:0]   irq_vec;
        logic [XLEN-1:0] pc;
        logic [DSW-1:0]  dslot;
        logic [XLEN-1:0] ccs;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] ksp;
        logic [XLEN-1:0] ebp;
    } ctx_t;

    typedef struct packed {
        st_e             st;
        ctx_t            ctx;
        logic [XLEN-1:0] data;
    } seq_t;

    seq_t q, d;

    logic [VW-1:0]   vec;
    logic            to_nrp;
    logic [XLEN-1:0] ccs_new;
    logic [XLEN-1:0] ret_addr;
    logic [XLEN-1:0] exs_word;
    logic [XLEN-1:0] tbl_addr;
    logic            in_save;
    logic            bad_entry;
    logic            good_save;

    exc_vec_sel #(.VW(VW)) u_vec (
        .evt_i       (q.ctx.evt),
        .trap_vec_i  (q.ctx.trap_vec),
        .fault_vec_i (q.ctx.fault_vec),
        .irq_vec_i   (q.ctx.irq_vec),
        .vec_o       (vec),
        .to_nrp_o    (to_nrp)
    );

    exc_ccs_xform #(
        .XLEN(XLEN), .M_BIT(M_BIT), .KEEP_TOP(KEEP_TOP), .MODE_SHIFT(MODE_SHIFT)
    ) u_ccs (
        .ccs_i    (q.ctx.ccs),
        .clr_m_i  (to_nrp),
        .legacy_i (q.ctx.legacy),
        .ccs_o    (ccs_new)
    );

    exc_ret_calc #(
        .XLEN(XLEN), .DSW(DSW), .VW(VW), .EXS_LSB(EXS_LSB)
    ) u_ret (
        .pc_i       (q.ctx.pc),
        .dslot_i    (q.ctx.dslot),
        .legacy_i   (q.ctx.legacy),
        .vec_i      (vec),
        .ebp_i      (q.ctx.ebp),
        .ret_o      (ret_addr),
        .exs_o      (exs_word),
        .tbl_addr_o (tbl_addr)
    );

    // Next-state process
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.ctx.evt       = evt_e'(evt_i);
                    d.ctx.legacy    = (core_ver_i < LEG_LIM);
                    d.ctx.trap_vec  = trap_vec_i;
                    d.ctx.fault_vec = fault_vec_i;
                    d.ctx.irq_vec   = irq_vec_i;
                    d.ctx.pc        = pc_i;
                    d.ctx.dslot     = dslot_i;
                    d.ctx.ccs       = ccs_i;
                    d.ctx.sp        = sp_i;
                    d.ctx.ksp       = ksp_i;
                    d.ctx.ebp       = ebp_i;
                    d.st            = ST_SAVE;
                end
            end
            ST_SAVE: begin
                d.st = bad_entry ? ST_IDLE : ST_FREQ;
            end
            ST_FREQ: begin
                if (rd_gnt_i) begin
                    d.st = ST_FWAIT;
                end
            end
            ST_FWAIT: begin
                if (rd_valid_i) begin
                    d.data = rd_data_i;
                    d.st   = ST_DONE;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Output decode
    always_comb begin
        in_save   = (q.st == ST_SAVE);
        bad_entry = in_save && q.ctx.legacy && (q.ctx.evt == EV_BUSF);
        good_save = in_save && !bad_entry;
    end

    assign erp_we_o    = good_save && !to_nrp;
    assign nrp_we_o    = good_save && to_nrp;
    assign ret_addr_o  = ret_addr;
    assign exs_we_o    = good_save && !q.ctx.legacy;
    assign exs_o       = exs_word;
    assign ccs_we_o    = good_save;
    assign ccs_o       = ccs_new;
    assign usp_we_o    = good_save && q.ctx.ccs[U_BIT];
    assign usp_o       = q.ctx.sp;
    assign sp_we_o     = good_save && q.ctx.ccs[U_BIT];
    assign sp_o        = q.ctx.ksp;
    assign dslot_clr_o = good_save && !q.ctx.legacy && (q.ctx.dslot != '0);
    assign irq_lock_o  = good_save && q.ctx.legacy;
    assign err_o       = bad_entry;
    assign rd_req_o    = (q.st == ST_FREQ);
    assign rd_addr_o   = tbl_addr;
    assign pc_we_o     = (q.st == ST_DONE);
    assign pc_o        = q.data;
    assign done_o      = (q.st == ST_DONE);

    // Assertions
    a_r2_ret_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start_i) |=> ((erp_we_o ^ nrp_we_o) || err_o));

    a_r7_ccs_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ccs_we_o && !irq_lock_o) |-> (ccs_o[MODE_SHIFT-1:0] == '0));

    a_r4_exs_fields: assert property (@(posedge clk) disable iff (!rst_n)
        exs_we_o |-> ((exs_o[EXS_LSB-1:0] == '0) && (exs_o >> (EXS_LSB + VW)) == '0));

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_valid_i));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_err_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!rd_req_o && !err_o && !done_o));

    a_r11_ctx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.ctx));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  evt_i = '0;
    logic [7:0]  core_ver_i = '0;
    logic [7:0]  trap_vec_i = '0, fault_vec_i = '0, irq_vec_i = '0;
    logic [31:0] pc_i = '0, ccs_i = '0, sp_i = '0, ksp_i = '0, ebp_i = '0;
    logic [1:0]  dslot_i = '0;
    logic        rd_gnt_i = 1'b0, rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;

    logic        erp_we_o, nrp_we_o, exs_we_o, ccs_we_o, usp_we_o, sp_we_o;
    logic        dslot_clr_o, irq_lock_o, err_o, rd_req_o, pc_we_o, done_o;
    logic [31:0] ret_addr_o, exs_o, ccs_o, usp_o, sp_o, rd_addr_o, pc_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .evt_i(evt_i),
        .core_ver_i(core_ver_i), .trap_vec_i(trap_vec_i),
        .fault_vec_i(fault_vec_i), .irq_vec_i(irq_vec_i), .pc_i(pc_i),
        .dslot_i(dslot_i), .ccs_i(ccs_i), .sp_i(sp_i), .ksp_i(ksp_i),
        .ebp_i(ebp_i), .erp_we_o(erp_we_o), .nrp_we_o(nrp_we_o),
        .ret_addr_o(ret_addr_o), .exs_we_o(exs_we_o), .exs_o(exs_o),
        .ccs_we_o(ccs_we_o), .ccs_o(ccs_o), .usp_we_o(usp_we_o),
        .usp_o(usp_o), .sp_we_o(sp_we_o), .sp_o(sp_o),
        .dslot_clr_o(dslot_clr_o), .irq_lock_o(irq_lock_o), .err_o(err_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .pc_we_o(pc_we_o),
        .pc_o(pc_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_vec(input logic [1:0] c, input logic [7:0] t, input logic [7:0] f, input logic [7:0] i);
        case (c)
            2'd0: return t;
            2'd1: return 8'd0;
            2'd2: return f;
            default: return i;
        endcase
    endfunction

    function automatic logic [31:0] f_ccs(input logic [31:0] c0, input logic [1:0] c, input bit leg);
        logic [31:0] c1;
        c1 = c0;
        if (c == 2'd1) c1[30] = 1'b0;
        if (leg) return c1;
        return ((c1 & 32'hC000_0000) | ((c1 << 12) >> 2)) & ~32'h0000_03FF;
    endfunction

    function automatic logic [31:0] f_mem(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C5A_A5C3;
    endfunction

    task automatic scramble();
        evt_i = 2'($urandom); core_ver_i = 8'($urandom);
        trap_vec_i = 8'($urandom); fault_vec_i = 8'($urandom); irq_vec_i = 8'($urandom);
        pc_i = $urandom; ccs_i = $urandom; sp_i = $urandom; ksp_i = $urandom;
        ebp_i = $urandom; dslot_i = 2'($urandom);
    endtask

    // Called at a negedge while idle; returns at a negedge while idle.
    task automatic run_evt(input logic [1:0] c, input logic [7:0] ver, input logic [7:0] tv,
                           input logic [7:0] fv, input logic [7:0] iv, input logic [31:0] pc,
                           input logic [1:0] ds, input logic [31:0] ccs, input logic [31:0] sp,
                           input logic [31:0] ksp, input logic [31:0] ebp,
                           input int gwait, input int vwait, input bit jam);
        bit leg;
        logic [7:0] v;
        logic [31:0] ret, addr, exp_pc;
        bit usr;
        leg = (ver < 8'd32);
        v = f_vec(c, tv, fv, iv);
        ret = leg ? pc : pc - {30'd0, ds};
        addr = ebp + ({24'd0, v} << 2);
        exp_pc = f_mem(addr);
        usr = ccs[6];
        evt_i = c; core_ver_i = ver; trap_vec_i = tv; fault_vec_i = fv; irq_vec_i = iv;
        pc_i = pc; dslot_i = ds; ccs_i = ccs; sp_i = sp; ksp_i = ksp; ebp_i = ebp;
        start_i = 1'b1;
        @(negedge clk);
        // save cycle
        if (jam) scramble(); else start_i = 1'b0;
        if (leg && c == 2'd2) begin
            chk(err_o == 1'b1, "R10 err pulse", {31'd0, err_o}, 32'd1);
            chk({erp_we_o, nrp_we_o, exs_we_o, ccs_we_o, usp_we_o, sp_we_o, dslot_clr_o, irq_lock_o} == '0,
                "R10 no writes", {24'd0, erp_we_o, nrp_we_o, exs_we_o, ccs_we_o, usp_we_o, sp_we_o, dslot_clr_o, irq_lock_o}, 32'd0);
            @(negedge clk);
            start_i = 1'b0;
            chk(!rd_req_o && !err_o && !done_o, "R10 idle after error", {29'd0, rd_req_o, err_o, done_o}, 32'd0);
            return;
        end
        chk(err_o == 1'b0, "R10 no err", {31'd0, err_o}, 32'd0);
        chk(erp_we_o == (c != 2'd1) && nrp_we_o == (c == 2'd1), "R2 return target",
            {30'd0, erp_we_o, nrp_we_o}, {30'd0, c != 2'd1, c == 2'd1});
        chk(ret_addr_o == ret, "R5 return address", ret_addr_o, ret);
        chk(dslot_clr_o == (!leg && ds != 2'd0), "R5 dslot clear", {31'd0, dslot_clr_o}, {31'd0, !leg && ds != 2'd0});
        chk(ccs_we_o && ccs_o == f_ccs(ccs, c, leg), "R7 R3 status word", ccs_o, f_ccs(ccs, c, leg));
        if (c == 2'd1) chk(ccs_o[30] == 1'b0, "R3 mode flag cleared", ccs_o, ccs_o & ~32'h4000_0000);
        chk(exs_we_o == !leg, "R4 exs enable", {31'd0, exs_we_o}, {31'd0, !leg});
        if (!leg) chk(exs_o == ({24'd0, v} << 8), "R4 exs word", exs_o, {24'd0, v} << 8);
        chk(usp_we_o == usr && sp_we_o == usr, "R6 swap enables", {30'd0, usp_we_o, sp_we_o}, {30'd0, usr, usr});
        if (usr) chk(usp_o == sp && sp_o == ksp, "R6 swap values", usp_o, sp);
        chk(irq_lock_o == leg, "R9 irq lock", {31'd0, irq_lock_o}, {31'd0, leg});
        chk(!rd_req_o, "R8 no request in save", {31'd0, rd_req_o}, 32'd0);
        @(negedge clk);
        // fetch request
        if (jam) scramble();
        for (int k = 0; k < gwait; k++) begin
            chk(rd_req_o && rd_addr_o == addr, "R1 R8 held request", rd_addr_o, addr);
            @(negedge clk);
            if (jam) scramble();
        end
        chk(rd_req_o && rd_addr_o == addr, "R1 R11 read address", rd_addr_o, addr);
        rd_gnt_i = 1'b1;
        @(negedge clk);
        rd_gnt_i = 1'b0;
        if (jam) scramble();
        for (int k = 0; k < vwait; k++) begin
            chk(!rd_req_o && !done_o, "R8 waiting for data", {30'd0, rd_req_o, done_o}, 32'd0);
            @(negedge clk);
            if (jam) scramble();
        end
        rd_valid_i = 1'b1;
        rd_data_i = exp_pc;
        @(negedge clk);
        rd_valid_i = 1'b0;
        rd_data_i = $urandom;
        start_i = 1'b0;
        chk(done_o && pc_we_o && pc_o == exp_pc, "R8 R11 new pc", pc_o, exp_pc);
        @(negedge clk);
        chk(!done_o && !pc_we_o && !rd_req_o, "R8 done single pulse", {30'd0, done_o, rd_req_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({erp_we_o, nrp_we_o, exs_we_o, ccs_we_o, usp_we_o, sp_we_o, dslot_clr_o,
             irq_lock_o, err_o, rd_req_o, pc_we_o, done_o} == '0, "R12 reset outputs", 32'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req_o && !done_o && !err_o, "R12 idle after reset", {29'd0, rd_req_o, done_o, err_o}, 32'd0);

        // Directed corners
        run_evt(2'd1, 8'd40, 8'h11, 8'h22, 8'h33, 32'h0000_1000, 2'd3, 32'hFFFF_FFFF,
                32'hAAAA_0000, 32'h5555_0000, 32'h8000_0000, 0, 0, 0);          // NMI, user, dslot, shift
        run_evt(2'd0, 8'd31, 8'h7F, 8'h00, 8'h00, 32'h0000_2002, 2'd2, 32'h4000_0040,
                32'h1234_5678, 32'h8765_4321, 32'h0000_4000, 2, 1, 0);          // legacy break, no rewind
        run_evt(2'd2, 8'd31, 8'h00, 8'h44, 8'h00, 32'h0000_3000, 2'd1, 32'h0000_0040,
                32'h0, 32'h0, 32'h0, 0, 0, 1);                                 // legacy bus fault: error, jam
        run_evt(2'd2, 8'd32, 8'h00, 8'h44, 8'h00, 32'h0000_3000, 2'd0, 32'h0000_0000,
                32'h0, 32'h0, 32'h0000_1000, 1, 0, 0);                         // newer bus fault at boundary
        run_evt(2'd3, 8'd255, 8'h00, 8'h00, 8'hFF, 32'h0, 2'd0, 32'h8000_0200,
                32'h0, 32'h0, 32'hFFFF_FFF0, 3, 4, 1);                         // address wrap, busy start ignored
        run_evt(2'd1, 8'd0, 8'h99, 8'h99, 8'h99, 32'h0000_0001, 2'd3, 32'hC000_0000,
                32'h0, 32'h0, 32'h0000_0100, 0, 2, 0);                         // legacy NMI

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [1:0] c;
            logic [7:0] ver;
            c = 2'($urandom);
            ver = ($urandom % 4 == 0) ? 8'($urandom % 32) : 8'(32 + $urandom % 224);
            run_evt(c, ver, 8'($urandom), 8'($urandom), 8'($urandom), $urandom, 2'($urandom),
                    $urandom, $urandom, $urandom, $urandom,
                    int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2));
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule